// File: doc/BRIEF.md
# INT8 Tile Dot-Product Accumulator

This block multiplies two small tiles of 8-bit integers and adds the product into a tile of 32-bit accumulators: C += A × B. Three row-organised register arrays hold the operands. A holds M rows of K bytes. B holds K/4 rows in a packed layout: row g lane n carries the four bytes that meet A columns 4g..4g+3 for output column n. C holds M rows of N 32-bit lanes. Each array is loaded one row per cycle through its own write port. C can be read one row at a time through a combinational read port.

A `start` pulse takes a shape (M, K in bytes, N) and two signedness bits. The first bit applies to A and the second to B, so all four signed/unsigned pairings are available. The engine then handles one four-byte group per cycle, updating every enabled lane of the current C row. It visits all groups of a row before it moves to the next row. After the last update it pulses `done`. A shape outside the legal range is refused with an `err` pulse, and the tiles are not changed.

Top module: `tile_dp_accum`

## Requirements
- R1: After reset `busy`, `done` and `err` are low and every C row reads as zero.
- R2: For each row m < M, group g < K/4 and lane n < N, C[m][n] gains the sum over i = 0..3 of A[m][4g+i] × B[g][4n+i]. A byte j of a row sits at bits [8j+7:8j]. B byte 4n+i and C lane n sit at bits [32n+8i+7:32n+8i] and [32n+31:32n].
- R3: `a_signed` = 1 treats A bytes as two's complement and 0 treats them as unsigned. `b_signed` does the same for B, independently of `a_signed`. All four pairings give the exact integer products.
- R4: Results are added onto the C contents present at start, modulo 2^32, without saturation.
- R5: Lanes n ≥ N of rows m < M, and all rows m ≥ M, keep their values.
- R6: `busy` is high for exactly M×K/4 cycles, beginning in the cycle after the accepted `start`. `done` is high for exactly one cycle, in the cycle right after `busy` falls.
- R7: A shape is illegal when M = 0 or M > 16, N = 0 or N > 16, or K = 0, K > 64 or K not a multiple of 4. On `start` with an illegal shape, `err` is high for one cycle in the next cycle, `busy` and `done` stay low, and C is unchanged.
- R8: While `busy` is high, the A, B and C row writes and any further `start` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr_en | input | 1 | Write one A row |
| a_wr_row | input | 4 | A row index |
| a_wr_data | input | 512 | A row bytes |
| b_wr_en | input | 1 | Write one packed B row |
| b_wr_row | input | 4 | B row index |
| b_wr_data | input | 512 | B row bytes |
| c_wr_en | input | 1 | Write one C row |
| c_wr_row | input | 4 | C row index |
| c_wr_data | input | 512 | C row lanes |
| c_rd_row | input | 4 | C row to read |
| c_rd_data | output | 512 | C row contents, combinational |
| start | input | 1 | Begin an accumulate pass |
| shp_rows | input | 5 | M, output rows |
| shp_k | input | 7 | K, A row length in bytes |
| shp_cols | input | 5 | N, output lanes |
| a_signed | input | 1 | A bytes are two's complement |
| b_signed | input | 1 | B bytes are two's complement |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-shape pulse |

## Verification
The shape and signedness inputs are sampled only in the cycle `start` is seen while idle. The assertions that relate a completion or error pulse to an earlier start rely on `start` being a single-cycle pulse from the driver. The bench keeps to that rule. It also keeps row indices within the 16-row arrays, and it draws random shapes only from the legal set. It deliberately breaks the rules in two places. The directed illegal-shape cases push each dimension just past its limit. The disturbance case issues row writes and a second start while a pass is running, so that the no-effect claims are tested at the C read port.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
    localparam int unsigned TDP_GRP_BYTES = 4;
    localparam int unsigned TDP_WORD_W    = 8 * TDP_GRP_BYTES;

    typedef logic [TDP_WORD_W-1:0] tdp_word_t;
    typedef logic signed [8:0]     tdp_ext_t;

    // Widen one byte to nine bits, sign- or zero-extended by mode.
    function automatic tdp_ext_t tdp_widen(input logic [7:0] v, input logic sgn);
        return {sgn & v[7], v};
    endfunction
endpackage

// File: rtl/tdp_dot4.sv
module tdp_dot4
    import tdp_pkg::*;
(
    input  tdp_word_t a_word,
    input  tdp_word_t b_word,
    input  logic      a_sgn,
    input  logic      b_sgn,
    output tdp_word_t dot
);
    logic signed [17:0]           ea, eb, prod;
    logic signed [TDP_WORD_W-1:0] acc;

    always_comb begin
        acc = '0;
        ea  = '0;
        eb  = '0;
        prod = '0;
        for (int i = 0; i < int'(TDP_GRP_BYTES); i++) begin
            ea   = 18'(tdp_widen(a_word[8*i +: 8], a_sgn));
            eb   = 18'(tdp_widen(b_word[8*i +: 8], b_sgn));
            prod = ea * eb;
            acc  = acc + TDP_WORD_W'(prod);
        end
        dot = tdp_word_t'(acc);
    end
endmodule

// File: rtl/tdp_walker.sv
module tdp_walker
    import tdp_pkg::*;
#(
    parameter int unsigned ROWS   = 16,
    parameter int unsigned GROUPS = 16,
    parameter int unsigned LANES  = 16,
    localparam int unsigned MW     = $clog2(ROWS + 1),
    localparam int unsigned KW     = $clog2(TDP_GRP_BYTES * GROUPS + 1),
    localparam int unsigned NW     = $clog2(LANES + 1),
    localparam int unsigned RIDX_W = $clog2(ROWS),
    localparam int unsigned GIDX_W = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MW-1:0]     shp_rows,
    input  logic [KW-1:0]     shp_k,
    input  logic [NW-1:0]     shp_cols,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [RIDX_W-1:0] cur_m,
    output logic [GIDX_W-1:0] cur_g,
    output logic [NW-1:0]     lane_lim,
    output logic              a_sgn,
    output logic              b_sgn
);
    localparam int unsigned KMAX = TDP_GRP_BYTES * GROUPS;

    typedef struct packed {
        logic              run;
        logic [RIDX_W-1:0] m;
        logic [RIDX_W-1:0] m_max;
        logic [GIDX_W-1:0] g;
        logic [GIDX_W-1:0] g_max;
        logic [NW-1:0]     lim;
        logic              a_sgn;
        logic              b_sgn;
        logic              done;
        logic              err;
    } wk_t;

    wk_t wk_d, wk_q;

    logic          rows_ok, cols_ok, k_ok, shape_ok;
    logic [KW-1:0] k_grp;

    always_comb begin
        rows_ok  = (shp_rows != '0) && (shp_rows <= MW'(ROWS));
        cols_ok  = (shp_cols != '0) && (shp_cols <= NW'(LANES));
        k_ok     = (shp_k != '0) && (shp_k <= KW'(KMAX)) && (shp_k[1:0] == 2'b00);
        shape_ok = rows_ok && cols_ok && k_ok;
        k_grp    = shp_k >> 2;
    end

    always_comb begin
        wk_d      = wk_q;
        wk_d.done = 1'b0;
        wk_d.err  = 1'b0;
        if (!wk_q.run) begin
            if (start) begin
                if (shape_ok) begin
                    wk_d.run   = 1'b1;
                    wk_d.m     = '0;
                    wk_d.g     = '0;
                    wk_d.m_max = RIDX_W'(shp_rows - 1'b1);
                    wk_d.g_max = GIDX_W'(k_grp - 1'b1);
                    wk_d.lim   = shp_cols;
                    wk_d.a_sgn = a_signed;
                    wk_d.b_sgn = b_signed;
                end else begin
                    wk_d.err = 1'b1;
                end
            end
        end else if (wk_q.g == wk_q.g_max) begin
            wk_d.g = '0;
            if (wk_q.m == wk_q.m_max) begin
                wk_d.run  = 1'b0;
                wk_d.done = 1'b1;
            end else begin
                wk_d.m = wk_q.m + 1'b1;
            end
        end else begin
            wk_d.g = wk_q.g + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q <= '0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign busy     = wk_q.run;
    assign done     = wk_q.done;
    assign err      = wk_q.err;
    assign cur_m    = wk_q.m;
    assign cur_g    = wk_q.g;
    assign lane_lim = wk_q.lim;
    assign a_sgn    = wk_q.a_sgn;
    assign b_sgn    = wk_q.b_sgn;

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done));
    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(start) && !$past(busy)));
    p_index_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cur_m <= wk_q.m_max && cur_g <= wk_q.g_max));
endmodule

// File: rtl/tile_dp_accum.sv
module tile_dp_accum
    import tdp_pkg::*;
#(
    parameter int unsigned ROWS      = 16,
    parameter int unsigned ROW_BYTES = 64,
    localparam int unsigned GROUPS = ROW_BYTES / TDP_GRP_BYTES,
    localparam int unsigned LANES  = GROUPS,
    localparam int unsigned ROW_W  = 8 * ROW_BYTES,
    localparam int unsigned MW     = $clog2(ROWS + 1),
    localparam int unsigned KW     = $clog2(ROW_BYTES + 1),
    localparam int unsigned NW     = $clog2(LANES + 1),
    localparam int unsigned RIDX_W = $clog2(ROWS),
    localparam int unsigned GIDX_W = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr_en,
    input  logic [RIDX_W-1:0] a_wr_row,
    input  logic [ROW_W-1:0]  a_wr_data,
    input  logic              b_wr_en,
    input  logic [RIDX_W-1:0] b_wr_row,
    input  logic [ROW_W-1:0]  b_wr_data,
    input  logic              c_wr_en,
    input  logic [RIDX_W-1:0] c_wr_row,
    input  logic [ROW_W-1:0]  c_wr_data,
    input  logic [RIDX_W-1:0] c_rd_row,
    output logic [ROW_W-1:0]  c_rd_data,
    input  logic              start,
    input  logic [MW-1:0]     shp_rows,
    input  logic [KW-1:0]     shp_k,
    input  logic [NW-1:0]     shp_cols,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic              busy,
    output logic              done,
    output logic              err
);
    typedef logic [LANES-1:0][TDP_WORD_W-1:0] row_t;

    row_t a_d [ROWS];
    row_t a_q [ROWS];
    row_t b_d [ROWS];
    row_t b_q [ROWS];
    row_t c_d [ROWS];
    row_t c_q [ROWS];

    logic [RIDX_W-1:0] cur_m;
    logic [GIDX_W-1:0] cur_g;
    logic [NW-1:0]     lane_lim;
    logic              a_sgn, b_sgn;

    tdp_word_t a_grp;
    row_t      b_row;
    row_t      c_row;
    row_t      lane_dot;
    row_t      acc_row;

    tdp_walker #(
        .ROWS   (ROWS),
        .GROUPS (GROUPS),
        .LANES  (LANES)
    ) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .shp_rows (shp_rows),
        .shp_k    (shp_k),
        .shp_cols (shp_cols),
        .a_signed (a_signed),
        .b_signed (b_signed),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .cur_m    (cur_m),
        .cur_g    (cur_g),
        .lane_lim (lane_lim),
        .a_sgn    (a_sgn),
        .b_sgn    (b_sgn)
    );

    // Operand selection for the current (row, group) step.
    always_comb begin
        a_grp = a_q[cur_m][cur_g];
        b_row = b_q[32'(cur_g)];
        c_row = c_q[cur_m];
    end

    for (genvar n = 0; n < int'(LANES); n++) begin : g_lane
        tdp_dot4 u_dot (
            .a_word (a_grp),
            .b_word (b_row[n]),
            .a_sgn  (a_sgn),
            .b_sgn  (b_sgn),
            .dot    (lane_dot[n])
        );

        assign acc_row[n] = (NW'(n) < lane_lim) ? (c_row[n] + lane_dot[n]) : c_row[n];

        p_uu_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !a_sgn && !b_sgn) |-> !lane_dot[n][TDP_WORD_W-1]);
        p_lane_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && NW'(n) >= lane_lim) |=> (c_q[$past(cur_m)][n] == $past(c_row[n])));
    end

    // Tile storage next state: loads only while idle, accumulate while busy.
    always_comb begin
        a_d = a_q;
        b_d = b_q;
        c_d = c_q;
        if (busy) begin
            c_d[cur_m] = acc_row;
        end else begin
            if (a_wr_en) a_d[a_wr_row] = row_t'(a_wr_data);
            if (b_wr_en) b_d[b_wr_row] = row_t'(b_wr_data);
            if (c_wr_en) c_d[c_wr_row] = row_t'(c_wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < int'(ROWS); r++) begin
                a_q[r] <= '0;
                b_q[r] <= '0;
                c_q[r] <= '0;
            end
        end else begin
            a_q <= a_d;
            b_q <= b_d;
            c_q <= c_d;
        end
    end

    assign c_rd_data = ROW_W'(c_q[c_rd_row]);

    for (genvar r = 0; r < int'(ROWS); r++) begin : g_row_chk
        p_row_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && cur_m != RIDX_W'(r)) |=> (c_q[r] == $past(c_q[r])));
        p_a_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
            busy |=> (a_q[r] == $past(a_q[r])));
    end
endmodule

// File: tb/test_tile_dp_accum.sv
module test_tile_dp_accum;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS       = 16;
    localparam int LANES      = 16;
    localparam int ROW_W      = 512;
    localparam int WD_CYCLES  = 150000;

    logic clk = 1'b0;
    logic rst_n;
    logic a_wr_en, b_wr_en, c_wr_en;
    logic [3:0] a_wr_row, b_wr_row, c_wr_row, c_rd_row;
    logic [ROW_W-1:0] a_wr_data, b_wr_data, c_wr_data, c_rd_data;
    logic start;
    logic [4:0] shp_rows, shp_cols;
    logic [6:0] shp_k;
    logic a_signed, b_signed;
    logic busy, done, err;

    logic [ROW_W-1:0] ma [ROWS];
    logic [ROW_W-1:0] mb [ROWS];
    logic [ROW_W-1:0] mc [ROWS];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_dp_accum i_tile_dp_accum (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_wr_row(a_wr_row), .a_wr_data(a_wr_data),
        .b_wr_en(b_wr_en), .b_wr_row(b_wr_row), .b_wr_data(b_wr_data),
        .c_wr_en(c_wr_en), .c_wr_row(c_wr_row), .c_wr_data(c_wr_data),
        .c_rd_row(c_rd_row), .c_rd_data(c_rd_data),
        .start(start), .shp_rows(shp_rows), .shp_k(shp_k), .shp_cols(shp_cols),
        .a_signed(a_signed), .b_signed(b_signed),
        .busy(busy), .done(done), .err(err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_CYCLES) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD_CYCLES);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int ext8(logic [7:0] v, bit s);
        return s ? int'($signed(v)) : int'(v);
    endfunction

    task automatic chk(string req, longint unsigned act, longint unsigned exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_rows(string req);
        for (int r = 0; r < ROWS; r++) begin
            c_rd_row = 4'(r);
            #1;
            n_tests++;
            if (c_rd_data !== mc[r]) begin
                n_fail++;
                $display("FAIL %s row %0d: actual %h expected %h", req, r, c_rd_data, mc[r]);
            end
        end
    endtask

    task automatic put_row(int which, int r, logic [ROW_W-1:0] d);
        @(negedge clk);
        a_wr_en = 1'b0; b_wr_en = 1'b0; c_wr_en = 1'b0;
        case (which)
            0: begin a_wr_en = 1'b1; a_wr_row = 4'(r); a_wr_data = d; ma[r] = d; end
            1: begin b_wr_en = 1'b1; b_wr_row = 4'(r); b_wr_data = d; mb[r] = d; end
            default: begin c_wr_en = 1'b1; c_wr_row = 4'(r); c_wr_data = d; mc[r] = d; end
        endcase
        @(negedge clk);
        a_wr_en = 1'b0; b_wr_en = 1'b0; c_wr_en = 1'b0;
    endtask

    function automatic logic [ROW_W-1:0] rand_row();
        logic [ROW_W-1:0] v;
        for (int w = 0; w < 16; w++) v[32*w +: 32] = $urandom;
        return v;
    endfunction

    task automatic fill_all(logic [ROW_W-1:0] pa, logic [ROW_W-1:0] pb,
                            logic [ROW_W-1:0] pc, bit rnd);
        for (int r = 0; r < ROWS; r++) begin
            put_row(0, r, rnd ? rand_row() : pa);
            put_row(1, r, rnd ? rand_row() : pb);
            put_row(2, r, rnd ? rand_row() : pc);
        end
    endtask

    // Reference model of one pass.
    task automatic model(int m_n, int k_n, int n_n, bit as, bit bs);
        for (int m = 0; m < m_n; m++)
            for (int n = 0; n < n_n; n++) begin
                int acc;
                acc = int'(mc[m][32*n +: 32]);
                for (int g = 0; g < k_n/4; g++)
                    for (int i = 0; i < 4; i++)
                        acc += ext8(ma[m][8*(4*g+i) +: 8], as) * ext8(mb[g][8*(4*n+i) +: 8], bs);
                mc[m][32*n +: 32] = 32'(acc);
            end
    endtask

    task automatic run_op(int m_n, int k_n, int n_n, bit as, bit bs, bit legal,
                          bit disturb, string req);
        int cnt;
        @(negedge clk);
        shp_rows = 5'(m_n); shp_k = 7'(k_n); shp_cols = 5'(n_n);
        a_signed = as; b_signed = bs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (legal) begin
            cnt = 0;
            while (busy && cnt < 5000) begin
                cnt++;
                if (disturb && cnt == 2) begin
                    a_wr_en = 1'b1; a_wr_row = 4'd0; a_wr_data = {16{32'hDEAD_BEEF}};
                    c_wr_en = 1'b1; c_wr_row = 4'd9; c_wr_data = '1;
                    b_wr_en = 1'b1; b_wr_row = 4'd0; b_wr_data = '1;
                    start = 1'b1; shp_rows = 5'd1; shp_k = 7'd4; shp_cols = 5'd1;
                end else begin
                    a_wr_en = 1'b0; b_wr_en = 1'b0; c_wr_en = 1'b0; start = 1'b0;
                end
                @(negedge clk);
            end
            a_wr_en = 1'b0; b_wr_en = 1'b0; c_wr_en = 1'b0; start = 1'b0;
            chk({"R6 busy length ", req}, cnt, m_n * k_n / 4);
            chk({"R6 done pulse ", req}, done, 1);
            @(negedge clk);
            chk({"R6 done single ", req}, {busy, done}, 0);
            model(m_n, k_n, n_n, as, bs);
        end else begin
            chk({"R7 err raised ", req}, {err, busy, done}, 3'b100);
            @(negedge clk);
            chk({"R7 err single ", req}, {err, busy, done}, 0);
        end
        chk_rows(req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        a_wr_en = 0; b_wr_en = 0; c_wr_en = 0;
        a_wr_row = 0; b_wr_row = 0; c_wr_row = 0; c_rd_row = 0;
        a_wr_data = '0; b_wr_data = '0; c_wr_data = '0;
        start = 0; shp_rows = 0; shp_k = 0; shp_cols = 0; a_signed = 0; b_signed = 0;
        for (int r = 0; r < ROWS; r++) begin ma[r] = '0; mb[r] = '0; mc[r] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 flags", {busy, done, err}, 0);
        chk_rows("R1 c zero");

        // R3: extreme bytes in every signedness pairing
        fill_all({64{8'h80}}, {64{8'h80}}, '0, 0);
        run_op(16, 64, 16, 1, 1, 1, 0, "R3 ss");
        run_op(16, 64, 16, 1, 0, 1, 0, "R3 su");
        run_op(16, 64, 16, 0, 1, 1, 0, "R3 us");
        run_op(16, 64, 16, 0, 0, 1, 0, "R3 uu");
        fill_all({64{8'hFF}}, {64{8'h7F}}, '0, 0);
        run_op(4, 16, 16, 1, 1, 1, 0, "R3 ss mixed");
        run_op(4, 16, 16, 0, 1, 1, 0, "R3 us mixed");

        // R4: wrap past 2^32
        fill_all({64{8'hFF}}, {64{8'hFF}}, {16{32'hFFFF_FFF0}}, 0);
        run_op(2, 8, 16, 0, 0, 1, 0, "R4 wrap");

        // R5: partial shape leaves other rows and lanes alone
        fill_all('0, '0, '0, 1);
        run_op(3, 8, 5, 1, 0, 1, 0, "R5 partial");
        run_op(1, 4, 1, 0, 1, 1, 0, "R5 minimal");

        // R7: illegal shapes
        run_op(4, 6, 4, 1, 1, 0, 0, "R7 k not mult4");
        run_op(0, 8, 4, 1, 1, 0, 0, "R7 m zero");
        run_op(4, 8, 17, 1, 1, 0, 0, "R7 n over");
        run_op(4, 68, 4, 1, 1, 0, 0, "R7 k over");
        run_op(17, 8, 4, 1, 1, 0, 0, "R7 m over");
        run_op(4, 0, 4, 1, 1, 0, 0, "R7 k zero");

        // R8: writes and start during a pass have no effect
        run_op(4, 64, 16, 1, 1, 1, 1, "R8 disturb");
        run_op(1, 64, 16, 0, 0, 1, 0, "R8 a row kept");

        // R2: random shapes, contents and modes
        for (int t = 0; t < 12; t++) begin
            int m_n, k_n, n_n;
            m_n = 1 + int'($urandom % 16);
            k_n = 4 * (1 + int'($urandom % 16));
            n_n = 1 + int'($urandom % 16);
            if (t % 4 == 0) fill_all('0, '0, '0, 1);
            run_op(m_n, k_n, n_n, 1'($urandom), 1'($urandom), 1, 0, "R2 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule